// File: doc/BRIEF.md
# UART Modem Control and Internal Loopback Unit

This block holds the eight-bit modem control register of one UART channel and turns its contents into the channel's modem pins and mode selects. The low five bits drive the active-low terminal-ready and request-to-send pins and the general output pin. They also gate the interrupt pin's output enable, provide a FIFO-ready enable, and switch the channel into internal loopback. The upper three bits pick a divide-by-four clock prescaler, open access to the trigger registers, and turn on the Xon-Any feature. These three bits can only change while an external enhanced-feature enable is high. When the hardware auto-RTS input is on, flow-control logic outside this block takes over the request-to-send pin.

The unit also produces the modem status byte. Its upper nibble shows the current modem lines. These are the carrier-detect, ring, data-set-ready and clear-to-send pins after a synchroniser. In loopback they are four of the control bits instead. The lower nibble holds sticky delta flags, and a status read clears them. In loopback the transmit stream is turned back into the receiver, and the external pins are parked at their idle levels.

Top module: `modem_ctrl_unit`

## Requirements
- R1: After reset the control register reads 0x00, rtsN, dtrN and opN are 1, irqOe is 0, txPin follows txSerial, and the status byte reads 0x00 with all modem inputs high.
- R2: A write (wrCtrl=1) always loads bits 4..0 from wrData. Bits 7..5 load only when enhWrEn is 1 in that cycle, and otherwise keep their value. ctrlRdData always returns all eight stored bits on the cycle after the write.
- R3: Stored bit 7 drives clkDiv4, bit 6 drives trigRegAccess, bit 5 drives xonAnyEn, and bit 4 drives loopbackOn.
- R4: Outside loopback, with autoRtsEn=0, rtsN is the inverse of bit 1 and dtrN is the inverse of bit 0.
- R5: irqOe equals bit 3. Outside loopback, opN is the inverse of bit 3.
- R6: Outside loopback, when autoRtsEn=1, rtsN equals the inverse of hwRtsReq whatever bit 1 holds.
- R7: In loopback (bit 4 = 1), rtsN, dtrN, opN and txPin are 1, and rxToReceiver equals txSerial. Outside loopback, txPin equals txSerial and rxToReceiver equals rxPin.
- R8: In loopback, status bits 7..4 become {bit 3, bit 2, bit 0, bit 1} of the control register one clock after the register changes.
- R9: Outside loopback, status bits 7..4 are {~dcdN, ~riN, ~dsrN, ~ctsN}. The value appears SYNC_STAGES+1 clocks after a pin change.
- R10: A change of status bit 4, 5 or 7 sets delta bit 0, 1 or 3 respectively. Delta bit 2 sets only when status bit 6 falls from 1 to 0. Deltas hold until a cycle with rdStatus=1, which clears them.
- R11: If a delta condition arises in the same cycle as rdStatus=1, that delta ends the cycle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrCtrl | input | 1 | Control register write strobe |
| wrData | input | 8 | Write data |
| enhWrEn | input | 1 | Write enable for control bits 7..5 |
| rdStatus | input | 1 | Status read strobe, clears deltas |
| autoRtsEn | input | 1 | Hardware flow control owns RTS |
| hwRtsReq | input | 1 | Hardware RTS request, 1 = assert |
| ctsN | input | 1 | Clear-to-send pin, active low |
| dsrN | input | 1 | Data-set-ready pin, active low |
| riN | input | 1 | Ring indicator pin, active low |
| dcdN | input | 1 | Carrier detect pin, active low |
| txSerial | input | 1 | Serial stream from transmitter |
| rxPin | input | 1 | External serial input |
| ctrlRdData | output | 8 | Stored control register |
| statusRdData | output | 8 | Modem status byte |
| rtsN | output | 1 | Request-to-send pin, active low |
| dtrN | output | 1 | Terminal-ready pin, active low |
| opN | output | 1 | General output pin, active low |
| irqOe | output | 1 | Interrupt pin output enable |
| clkDiv4 | output | 1 | Prescaler select, 1 = divide by 4 |
| trigRegAccess | output | 1 | Trigger register page select |
| xonAnyEn | output | 1 | Xon-Any enable |
| loopbackOn | output | 1 | Loopback mode active |
| txPin | output | 1 | External serial output |
| rxToReceiver | output | 1 | Serial stream to receiver |

## Verification
A status read that clears the deltas can fall in the same cycle as a new delta caused by a control write in loopback. The bench writes a control value whose loopback image changes a status bit, then pulses rdStatus on the very next cycle. That is the cycle in which the status nibble updates. The matching delta must read set afterwards, while a delta raised earlier and not renewed must read clear.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int REG_W   = 8;
  localparam int NIB_W   = 4;
  localparam int HI_LSB  = 5;
  localparam int B_DIV4  = 7;
  localparam int B_TRIG  = 6;
  localparam int B_XON   = 5;
  localparam int B_LOOP  = 4;
  localparam int B_OP    = 3;
  localparam int B_FRDY  = 2;
  localparam int B_RTS   = 1;
  localparam int B_DTR   = 0;
  // status nibble index: 3 carrier, 2 ring, 1 data-set-ready, 0 clear-to-send
  localparam int S_DCD   = 3;
  localparam int S_RI    = 2;
  localparam int S_DSR   = 1;
  localparam int S_CTS   = 0;

  typedef struct packed {
    logic wrLow;
    logic wrHigh;
    logic clrDelta;
  } mcr_strobe_t;
endpackage

// File: rtl/mcr_ctrl.sv
module mcr_ctrl
  import mcr_pkg::*;
(
  input  logic        wrCtrl,
  input  logic        enhWrEn,
  input  logic        rdStatus,
  output mcr_strobe_t strobes
);
  always_comb begin
    strobes.wrLow    = wrCtrl;
    strobes.wrHigh   = wrCtrl & enhWrEn;
    strobes.clrDelta = rdStatus;
  end
endmodule

// File: rtl/mcr_datapath.sv
module mcr_datapath
  import mcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  mcr_strobe_t      strobes,
  input  logic [REG_W-1:0] wrData,
  input  logic             autoRtsEn,
  input  logic             hwRtsReq,
  input  logic [NIB_W-1:0] pinActive,
  input  logic             txSerial,
  input  logic             rxPin,
  output logic [REG_W-1:0] ctrlQ,
  output logic [REG_W-1:0] statusQ,
  output logic             rtsN,
  output logic             dtrN,
  output logic             opN,
  output logic             irqOe,
  output logic             txPin,
  output logic             rxToReceiver
);
  localparam int LOW_W = HI_LSB;

  logic [NIB_W-1:0] syncOut;
  logic [NIB_W-1:0] srcNib;
  logic [NIB_W-1:0] curNib;
  logic [NIB_W-1:0] deltaQ;
  logic [NIB_W-1:0] setDelta;
  logic             loopMode;

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else begin
      if (strobes.wrLow)  ctrlQ[LOW_W-1:0]     <= wrData[LOW_W-1:0];
      if (strobes.wrHigh) ctrlQ[REG_W-1:HI_LSB] <= wrData[REG_W-1:HI_LSB];
    end
  end

  // modem line synchroniser
  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign syncOut = pinActive;
    end else begin : g_sync
      logic [NIB_W-1:0] chain [SYNC_STAGES];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
        end else begin
          chain[0] <= pinActive;
          for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign syncOut = chain[SYNC_STAGES-1];
    end
  endgenerate

  assign loopMode = ctrlQ[B_LOOP];

  always_comb begin
    if (loopMode) begin
      srcNib[S_DCD] = ctrlQ[B_OP];
      srcNib[S_RI]  = ctrlQ[B_FRDY];
      srcNib[S_DSR] = ctrlQ[B_DTR];
      srcNib[S_CTS] = ctrlQ[B_RTS];
    end else begin
      srcNib = syncOut;
    end
  end

  always_comb begin
    setDelta        = srcNib ^ curNib;
    setDelta[S_RI]  = curNib[S_RI] & ~srcNib[S_RI];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curNib <= '0;
      deltaQ <= '0;
    end else begin
      curNib <= srcNib;
      deltaQ <= (strobes.clrDelta ? '0 : deltaQ) | setDelta;
    end
  end

  assign statusQ = {curNib, deltaQ};

  // pin drive
  always_comb begin
    irqOe = ctrlQ[B_OP];
    if (loopMode) begin
      rtsN         = 1'b1;
      dtrN         = 1'b1;
      opN          = 1'b1;
      txPin        = 1'b1;
      rxToReceiver = txSerial;
    end else begin
      rtsN         = autoRtsEn ? ~hwRtsReq : ~ctrlQ[B_RTS];
      dtrN         = ~ctrlQ[B_DTR];
      opN          = ~ctrlQ[B_OP];
      txPin        = txSerial;
      rxToReceiver = rxPin;
    end
  end
endmodule

// File: rtl/modem_ctrl_unit.sv
module modem_ctrl_unit
  import mcr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrCtrl,
  input  logic [7:0] wrData,
  input  logic       enhWrEn,
  input  logic       rdStatus,
  input  logic       autoRtsEn,
  input  logic       hwRtsReq,
  input  logic       ctsN,
  input  logic       dsrN,
  input  logic       riN,
  input  logic       dcdN,
  input  logic       txSerial,
  input  logic       rxPin,
  output logic [7:0] ctrlRdData,
  output logic [7:0] statusRdData,
  output logic       rtsN,
  output logic       dtrN,
  output logic       opN,
  output logic       irqOe,
  output logic       clkDiv4,
  output logic       trigRegAccess,
  output logic       xonAnyEn,
  output logic       loopbackOn,
  output logic       txPin,
  output logic       rxToReceiver
);
  mcr_strobe_t      strobes;
  logic [NIB_W-1:0] pinActive;
  logic [REG_W-1:0] ctrlQ;

  assign pinActive = {~dcdN, ~riN, ~dsrN, ~ctsN};

  mcr_ctrl u_ctrl (
    .wrCtrl  (wrCtrl),
    .enhWrEn (enhWrEn),
    .rdStatus(rdStatus),
    .strobes (strobes)
  );

  mcr_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (wrData),
    .autoRtsEn   (autoRtsEn),
    .hwRtsReq    (hwRtsReq),
    .pinActive   (pinActive),
    .txSerial    (txSerial),
    .rxPin       (rxPin),
    .ctrlQ       (ctrlQ),
    .statusQ     (statusRdData),
    .rtsN        (rtsN),
    .dtrN        (dtrN),
    .opN         (opN),
    .irqOe       (irqOe),
    .txPin       (txPin),
    .rxToReceiver(rxToReceiver)
  );

  assign ctrlRdData    = ctrlQ;
  assign clkDiv4       = ctrlQ[B_DIV4];
  assign trigRegAccess = ctrlQ[B_TRIG];
  assign xonAnyEn      = ctrlQ[B_XON];
  assign loopbackOn    = ctrlQ[B_LOOP];
endmodule

// File: rtl/modem_ctrl_unit_chk.sv
module modem_ctrl_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrCtrl,
  input logic [7:0] wrData,
  input logic       enhWrEn,
  input logic       rdStatus,
  input logic       autoRtsEn,
  input logic       hwRtsReq,
  input logic       txSerial,
  input logic [7:0] ctrlRdData,
  input logic [7:0] statusRdData,
  input logic       rtsN,
  input logic       dtrN,
  input logic       opN,
  input logic       irqOe,
  input logic       txPin,
  input logic       rxToReceiver
);
  p_high_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !enhWrEn) |=> ctrlRdData[7:5] == $past(ctrlRdData[7:5]));

  p_low_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrCtrl |=> ctrlRdData[4:0] == $past(wrData[4:0]));

  p_loop_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdData[4] |-> (rtsN && dtrN && opN && txPin && rxToReceiver == txSerial));

  p_auto_rts_r6: assert property (@(posedge clk) disable iff (!rstN)
    (autoRtsEn && !ctrlRdData[4]) |-> rtsN == !hwRtsReq);

  p_op_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRdData[4] |-> irqOe == !opN);

  p_delta_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    rdStatus |=> (statusRdData[3:0] == 4'h0) ||
                 (statusRdData[7:4] != $past(statusRdData[7:4])));

  p_delta_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rdStatus |=> (statusRdData[3:0] & $past(statusRdData[3:0])) == $past(statusRdData[3:0]));
endmodule

bind modem_ctrl_unit modem_ctrl_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .wrCtrl(wrCtrl), .wrData(wrData), .enhWrEn(enhWrEn),
  .rdStatus(rdStatus), .autoRtsEn(autoRtsEn), .hwRtsReq(hwRtsReq),
  .txSerial(txSerial), .ctrlRdData(ctrlRdData), .statusRdData(statusRdData),
  .rtsN(rtsN), .dtrN(dtrN), .opN(opN), .irqOe(irqOe), .txPin(txPin),
  .rxToReceiver(rxToReceiver)
);

// File: tb/tb_modem_ctrl_unit.sv
module tb_modem_ctrl_unit;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrCtrl = 0, enhWrEn = 0, rdStatus = 0, autoRtsEn = 0, hwRtsReq = 0;
  logic [7:0] wrData = 8'h00;
  logic ctsN = 1, dsrN = 1, riN = 1, dcdN = 1, txSerial = 0, rxPin = 1;
  logic [7:0] ctrlRdData, statusRdData;
  logic rtsN, dtrN, opN, irqOe, clkDiv4, trigRegAccess, xonAnyEn, loopbackOn;
  logic txPin, rxToReceiver;

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  modem_ctrl_unit #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rstN(rstN), .wrCtrl(wrCtrl), .wrData(wrData), .enhWrEn(enhWrEn),
    .rdStatus(rdStatus), .autoRtsEn(autoRtsEn), .hwRtsReq(hwRtsReq),
    .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .dcdN(dcdN), .txSerial(txSerial),
    .rxPin(rxPin), .ctrlRdData(ctrlRdData), .statusRdData(statusRdData),
    .rtsN(rtsN), .dtrN(dtrN), .opN(opN), .irqOe(irqOe), .clkDiv4(clkDiv4),
    .trigRegAccess(trigRegAccess), .xonAnyEn(xonAnyEn), .loopbackOn(loopbackOn),
    .txPin(txPin), .rxToReceiver(rxToReceiver)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one clock edge; inputs are changed at negedge, outputs sampled at negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeCtrl(input logic [7:0] d, input logic enh);
    wrData = d; enhWrEn = enh; wrCtrl = 1'b1;
    tick();
    wrCtrl = 1'b0; enhWrEn = 1'b0;
    shadow = enh ? d : {shadow[7:5], d[4:0]};
  endtask

  task automatic readStatus();
    rdStatus = 1'b1;
    tick();
    rdStatus = 1'b0;
  endtask

  function automatic logic [3:0] loopNib(input logic [7:0] c);
    return {c[3], c[2], c[0], c[1]};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1 ctrl", ctrlRdData, 8'h00);
    check("R1 status", statusRdData, 8'h00);
    check("R1 pins", {5'b0, rtsN, dtrN, opN}, 8'h07);
    check("R1 irqOe", {7'b0, irqOe}, 8'h00);
    rstN = 1'b1;
    tick();
    check("R1 txPin", {7'b0, txPin}, {7'b0, txSerial});

    // R2/R3/R4/R5/R7/R8 exhaustive write sweep
    for (int e = 0; e < 2; e++) begin
      for (int d = 0; d < 256; d++) begin
        txSerial = d[0];
        writeCtrl(d[7:0], e[0]);
        check("R2 readback", ctrlRdData, shadow);
        check("R3 selects", {4'b0, clkDiv4, trigRegAccess, xonAnyEn, loopbackOn},
              {4'b0, shadow[7:4]});
        check("R5 irqOe", {7'b0, irqOe}, {7'b0, shadow[3]});
        if (shadow[4]) begin
          check("R7 loop pins", {4'b0, rtsN, dtrN, opN, txPin}, 8'h0F);
          check("R7 loop rx", {7'b0, rxToReceiver}, {7'b0, txSerial});
        end else begin
          check("R4 rts dtr", {6'b0, rtsN, dtrN}, {6'b0, ~shadow[1], ~shadow[0]});
          check("R5 opN", {7'b0, opN}, {7'b0, ~shadow[3]});
          check("R7 normal path", {6'b0, txPin, rxToReceiver}, {6'b0, txSerial, rxPin});
        end
        tick();
        check("R8 status nibble", {4'b0, statusRdData[7:4]},
              {4'b0, shadow[4] ? loopNib(shadow) : 4'h0});
        readStatus();
      end
    end

    // R6 auto-RTS overrides bit 1
    for (int m = 0; m < 8; m++) begin
      writeCtrl({6'b0, m[0], 1'b0}, 1'b0);
      autoRtsEn = m[1]; hwRtsReq = m[2];
      tick();
      check(m[1] ? "R6 auto rts" : "R4 manual rts", {7'b0, rtsN},
            {7'b0, m[1] ? ~m[2] : ~m[0]});
    end
    autoRtsEn = 0; hwRtsReq = 0;

    // R9/R10 normal-mode status and deltas
    writeCtrl(8'h00, 1'b1);
    tick(); readStatus();
    check("R10 cleared", statusRdData, 8'h00);
    for (int p = 0; p < 4; p++) begin
      logic [3:0] act;
      act = 4'b0001 << p;
      {dcdN, riN, dsrN, ctsN} = ~act;
      repeat (SYNC + 1) tick();
      check("R9 pin image", {4'b0, statusRdData[7:4]}, {4'b0, act});
      check("R10 leading delta", {4'b0, statusRdData[3:0]},
            {4'b0, (p == 2) ? 4'h0 : act});
      readStatus();
      check("R10 read clears", {4'b0, statusRdData[3:0]}, 8'h00);
      {dcdN, riN, dsrN, ctsN} = 4'hF;
      repeat (SYNC + 1) tick();
      check("R10 trailing delta", {4'b0, statusRdData[3:0]}, {4'b0, act});
      readStatus();
    end

    // R11 set wins over clear: write in loopback, read on the update cycle
    writeCtrl(8'h10, 1'b0);
    tick(); readStatus();
    writeCtrl(8'h11, 1'b0);           // DTR -> status bit 5 -> delta bit 1
    tick();                           // status updated here, delta bit1 set
    writeCtrl(8'h13, 1'b0);           // RTS -> status bit 4 -> delta bit 0
    readStatus();                     // coincides with bit-4 update
    check("R11 collision", {4'b0, statusRdData[3:0]}, 8'h01);
    check("R11 nibble", {4'b0, statusRdData[7:4]}, 8'h03);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule